// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block links two 18-bit buses, called A and B, through two independent one-way paths. The A-to-B path stores A data and presents it on B. The B-to-A path stores B data and presents it on A. Each path has its own storage element, and a per-direction level input and strobe input put that element into one of three modes:

- **Transparent:** the output follows the input.
- **Latched:** the stored value is held.
- **Clocked:** the input is captured on a falling edge of the strobe.

A per-direction enable decides whether the output port is driven. The A-to-B enable is active high. The B-to-A enable is active low.

Each port appears as three signals: an input vector, an output vector and a drive flag. Surrounding logic, or a pad ring, turns these into a real tristate bus. The whole block runs on one fast system clock, which is much faster than the strobe and level inputs. Those asynchronous inputs pass through two-stage synchronizers before they take effect. A falling edge of a strobe is seen as a registered high followed by a synchronized low. The data inputs are sampled directly and are expected to be stable around every control change.

Top module: `bus_xcvr`

## Requirements
- R1: While a path's transparent input (`ab_pass` or `ba_pass`) is high, that path's output vector equals its input vector. This holds from the second system clock edge after the transparent input rises, and it tracks every later change of the input vector.
- R2: While the transparent input is low, a high-to-low change of the path's strobe (`ab_strobe` or `ba_strobe`) captures the input vector. The captured value appears on the output by the third system clock edge after the strobe change.
- R3: While the transparent input is low, the output keeps its stored value under any of these conditions: the strobe stays high, the strobe stays low, the strobe rises, or the input vector changes.
- R4: When the transparent input falls with the strobe low, the output keeps the value that the input vector had while the path was still transparent.
- R5: `b_drive` equals `ab_en`, and `ab_en` is active high. When `ab_en` is low, the B port is not driven whatever the other inputs are. `b_out` still shows the path's current value.
- R6: `a_drive` is high exactly when `ba_en_n` is low, so the B-to-A enable is active low. When `ba_en_n` is high, the A port is not driven. Apart from this polarity, the B-to-A path behaves as R1 to R4 describe.
- R7: The two paths are independent. A change on one path's transparent input, strobe, enable or input vector leaves the other path's output vector and drive flag unchanged.
- R8: While `rst_n` is low, both drive flags are low. After a synchronous reset both stored values are zero, so with the transparent inputs low both output vectors read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 18 | Data arriving from the A bus |
| a_out | output | 18 | Data presented toward the A bus |
| a_drive | output | 1 | Drive the A bus when high |
| b_in | input | 18 | Data arriving from the B bus |
| b_out | output | 18 | Data presented toward the B bus |
| b_drive | output | 1 | Drive the B bus when high |
| ab_en | input | 1 | A-to-B output enable, active high |
| ab_pass | input | 1 | A-to-B transparent select, high = transparent |
| ab_strobe | input | 1 | A-to-B capture strobe, captures on a falling edge |
| ba_en_n | input | 1 | B-to-A output enable, active low |
| ba_pass | input | 1 | B-to-A transparent select, high = transparent |
| ba_strobe | input | 1 | B-to-A capture strobe, captures on a falling edge |

## Verification
A corrupted stored register shows at the output vector as soon as the transparent input is low. While that input is high the fault stays hidden, because the output follows the input. It then appears in the first cycle after the transparent input falls.

A wrong strobe-edge record shows up in two ways. It can cause a missed capture, which is visible three system edges after the strobe falls. It can also cause a false capture on a rising strobe, which is visible in the same window.

A path's output can pick up the other path's state. Because every control change checks both directions, this shows up at the very next check.

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int W    = 18,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  input  logic         ab_en,
  input  logic         ab_pass,
  input  logic         ab_strobe,
  input  logic         ba_en_n,
  input  logic         ba_pass,
  input  logic         ba_strobe
);
  localparam int TOP = SYNC - 1;

  logic [TOP:0] ab_pass_sh, ab_stb_sh, ba_pass_sh, ba_stb_sh;
  logic         ab_stb_q, ba_stb_q;
  logic [W-1:0] ab_q, ba_q;
  logic         ab_le_s, ba_le_s, ab_fall, ba_fall;

  generate
    if (SYNC == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ab_pass_sh <= '0; ab_stb_sh <= '0;
          ba_pass_sh <= '0; ba_stb_sh <= '0;
        end else begin
          ab_pass_sh <= ab_pass; ab_stb_sh <= ab_strobe;
          ba_pass_sh <= ba_pass; ba_stb_sh <= ba_strobe;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ab_pass_sh <= '0; ab_stb_sh <= '0;
          ba_pass_sh <= '0; ba_stb_sh <= '0;
        end else begin
          ab_pass_sh <= {ab_pass_sh[TOP-1:0], ab_pass};
          ab_stb_sh  <= {ab_stb_sh[TOP-1:0],  ab_strobe};
          ba_pass_sh <= {ba_pass_sh[TOP-1:0], ba_pass};
          ba_stb_sh  <= {ba_stb_sh[TOP-1:0],  ba_strobe};
        end
      end
    end
  endgenerate

  assign ab_le_s = ab_pass_sh[TOP];
  assign ba_le_s = ba_pass_sh[TOP];
  assign ab_fall = ab_stb_q & ~ab_stb_sh[TOP];
  assign ba_fall = ba_stb_q & ~ba_stb_sh[TOP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ab_stb_q <= 1'b0;
      ba_stb_q <= 1'b0;
      ab_q     <= '0;
      ba_q     <= '0;
    end else begin
      ab_stb_q <= ab_stb_sh[TOP];
      ba_stb_q <= ba_stb_sh[TOP];
      if (ab_le_s || ab_fall) ab_q <= a_in;
      if (ba_le_s || ba_fall) ba_q <= b_in;
    end
  end

  assign b_out   = ab_le_s ? a_in : ab_q;
  assign a_out   = ba_le_s ? b_in : ba_q;
  assign b_drive = rst_n & ab_en;
  assign a_drive = rst_n & ~ba_en_n;
endmodule

module xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q,
  input logic         ab_le_s,
  input logic         ba_le_s,
  input logic         ab_fall,
  input logic         ba_fall,
  input logic         ab_en,
  input logic         ba_en_n,
  input logic         a_drive,
  input logic         b_drive
);
  assert_pass_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le_s |=> ab_q == $past(a_in));
  assert_fall_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_fall && !ab_le_s) |=> ab_q == $past(a_in));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le_s && !ab_fall) |=> $stable(ab_q));
  assert_b_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_en |-> !b_drive);
  assert_a_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ba_en_n |-> !a_drive);
  assert_ba_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le_s && !ba_fall) |=> $stable(ba_q));
  assert_ba_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_le_s || ba_fall) |=> ba_q == $past(b_in));

  always @(posedge clk)
    if (!rst_n) assert_reset_off_R8: assert (!a_drive && !b_drive);
endmodule

bind bus_xcvr xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/test_bus_xcvr.sv
module test_bus_xcvr;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_drive, b_drive;
  logic         ab_en = 1'b1, ab_pass = 1'b0, ab_strobe = 1'b0;
  logic         ba_en_n = 1'b0, ba_pass = 1'b0, ba_strobe = 1'b0;

  int n_run = 0, n_fail = 0;
  logic [W-1:0] st_ab = '0, st_ba = '0;
  logic         pck_ab = 1'b0, pck_ba = 1'b0;
  string        tag_ab, tag_ba;

  always #2.5 clk = ~clk;

  bus_xcvr i_bus_xcvr (.*);

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp,
                     logic dact, logic dexp);
    n_run++;
    if (act !== exp || dact !== dexp) begin
      n_fail++;
      $display("FAIL %s: data %h drive %b, expected data %h drive %b",
               tag, act, dact, exp, dexp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_both();
    chk(tag_ab, b_out, ab_pass ? a_in : st_ab, b_drive, ab_en);
    chk(tag_ba, a_out, ba_pass ? b_in : st_ba, a_drive, !ba_en_n);
  endtask

  task automatic set_ctl(logic e1, logic l1, logic c1, logic e2, logic l2, logic c2);
    ab_en = e1; ab_pass = l1; ab_strobe = c1;
    ba_en_n = e2; ba_pass = l2; ba_strobe = c2;
    tag_ab = l1 ? "R1" : (pck_ab && !c1) ? "R2" : (ab_pass && !l1) ? "R4" : "R3";
    tag_ba = l2 ? "R6" : (pck_ba && !c2) ? "R6" : "R7";
    if (!e1) tag_ab = "R5";
    if (l1 || (pck_ab && !c1)) st_ab = a_in;
    if (l2 || (pck_ba && !c2)) st_ba = b_in;
    pck_ab = c1; pck_ba = c2;
    settle();
    check_both();
  endtask

  task automatic set_data(logic [W-1:0] da, logic [W-1:0] db);
    a_in = da; b_in = db;
    if (ab_pass) st_ab = da;
    if (ba_pass) st_ba = db;
    tag_ab = ab_pass ? "R1" : "R3";
    tag_ba = "R7";
    settle();
    check_both();
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    a_in = 18'h3FFFF; b_in = 18'h2AAAA;
    repeat (3) @(negedge clk);
    chk("R8", b_out, '0, b_drive, 1'b0);
    chk("R8", a_out, '0, a_drive, 1'b0);
    rst_n = 1'b1;
    settle();
    tag_ab = "R8"; tag_ba = "R8";
    check_both();

    for (int k = 0; k < 12; k++) begin
      logic [W-1:0] da, db;
      da = W'(k * 18'h1D2B7) ^ 18'h15555;
      db = W'(k * 18'h0B3C9) ^ 18'h2A5A5;
      for (int r = 0; r < 8; r++) begin
        logic e, l, c;
        e = r[2] ^ k[0]; l = r[1]; c = r[0] ^ k[1];
        set_ctl(e, l, c, ab_en, ba_pass, ba_strobe);
        set_data(da ^ W'(r * 18'h00F0F), db);
        set_ctl(ab_en, ab_pass, ab_strobe, e, ~l, c ^ k[2]);
        set_data(a_in, db ^ W'(r * 18'h0C3C3));
      end
      set_ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
      set_data(da, db);
      set_ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
      set_ctl(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      set_data(~da, ~db);
      set_ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R2", b_out, ~da, b_drive, 1'b1);
      chk("R6", a_out, ~db, a_drive, 1'b1);
      set_data(da, db);
      set_ctl(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      chk("R3", b_out, ~da, b_drive, 1'b1);
      set_ctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      set_ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      set_data(~da, ~db);
      chk("R4", b_out, da, b_drive, 1'b1);
      set_ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      chk("R5", b_out, da, b_drive, 1'b0);
      chk("R6", a_out, db, a_drive, 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule